// File: doc/BRIEF.md
# BCD calendar counter with test mode

The block keeps wall-clock time in six bytes: seconds, minutes, hours and day of month in BCD, one byte that packs a binary month with a weekday number, and a BCD year. A reference pulse at 32.768 kHz drives a 15-stage divider. The divider gives one advance per second while counting is enabled. A parallel load replaces the whole calendar at once. The live bytes are always visible on the output, so a host captures the time by sampling them.

For production test there is a fast mode. In this mode the normal second tick is blocked and the bytes are stepped directly at a quarter of the reference rate. The `oe` input picks between two step styles. With `oe` high the bytes form a single ripple counter. With `oe` low every byte counts on its own. Each style drives a one-bit flag in its own way. The `serial_mode` input decides whether the year byte takes part in loads, in year carry and in the test chain.

Top module: `cal_counter`

## Requirements
- R1: After reset the calendar reads seconds 00, minutes 00, hours 00, day 01, month 1 with weekday 0 (byte 4 = 0x10), year 00, and `test_flag` is 0. In `cal_bytes`, byte k sits at bits [8k+7:8k]. Byte 0 is seconds, 1 minutes, 2 hours, 3 day, 4 month/weekday and 5 year.
- R2: While counting is enabled and test mode is off, seconds advance by one BCD step on every 2^DIV_BITS-th reference pulse.
- R3: Seconds and minutes roll from 59 to 00 and hours roll from 23 to 00, each passing a carry to the next byte.
- R4: When the hours roll over, the weekday (low nibble of byte 4) steps 0..6 and wraps to 0. The day steps up to the month's last day, with February given 29 days when the BCD year is divisible by 4, and then returns to 01. The month (high nibble of byte 4) steps 1..12 and wraps to 1. When the month wraps and `serial_mode` is 1, the year steps 99 to 00.
- R5: With `serial_mode` 0 the year byte never changes: a load does not write it and the calendar does not carry into it.
- R6: With `run_en` low and test mode off, reference pulses leave the calendar unchanged.
- R7: A `load_stb` writes bytes 0..4 from `load_data` (and byte 5 when `serial_mode` is 1) at the next edge. It also halts counting until `run_en` rises again or test mode is left.
- R8: A load clears the upper divider stages and keeps the low KEEP_BITS stages running. The first second tick after the restart therefore comes exactly 2^DIV_BITS minus (low-stage phase) pulses later.
- R9: While `test_en` is high, no normal second tick occurs. The calendar steps once every 2^TEST_BITS reference pulses.
- R10: In test mode with `oe` high, byte 0 is incremented as a plain binary byte. Each byte passes the carry upward only when it wraps to 0x00. `test_flag` takes the value "top active byte was 0x00 before the step".
- R11: In test mode with `oe` low, every active byte is incremented in binary with no carry between bytes. `test_flag` becomes 1 when any of them wrapped to 0x00, and 0 otherwise.
- R12: The test chain covers bytes 0..5 when `serial_mode` is 1 and bytes 0..4 when it is 0.
- R13: When test mode is off, `test_flag` is 0 at the next edge. Leaving test mode also resumes normal counting without a fresh rise of `run_en`.
- R14: A load that arrives in the same cycle as a second tick or test step wins. The calendar takes exactly the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| load_stb | input | 1 | Parallel load (time set) strobe |
| load_data | input | 48 | Calendar value to load, same byte layout as `cal_bytes` |
| run_en | input | 1 | Counting enable; its rising edge restarts counting after a load |
| test_en | input | 1 | Selects fast test stepping |
| oe | input | 1 | Test step style: 1 ripple chain, 0 independent bytes |
| serial_mode | input | 1 | 1: year byte active (6 bytes); 0: 5 bytes |
| cal_bytes | output | 48 | Live calendar bytes |
| test_flag | output | 1 | Test-mode wrap flag |

## Verification
A time set and an advance can fall on the same clock edge: a load can meet a second tick, or in test mode a test step. The bench follows the low divider phase by counting every reference pulse it sends. From that count it works out the exact pulse on which the next second tick falls, and drives `load_stb` together with that pulse. The calendar must then read back exactly the loaded value with no extra increment, and counting must stay halted afterwards.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int CAL_BYTES = 6;
  localparam int PAR_BYTES = 5;
  localparam int CAL_W     = 8 * CAL_BYTES;

  typedef logic [CAL_BYTES-1:0][7:0] cal_t;

  typedef struct packed {
    logic       wrap;
    logic [7:0] val;
  } step8_t;

  typedef struct packed {
    cal_t cal;
    logic flag;
  } test_res_t;

  // year 00, month 1 / weekday 0, day 01, 00:00:00
  localparam cal_t CAL_RESET = 48'h00_10_01_00_00_00;

  // One BCD increment; wraps to 'first' after reaching 'last'.
  function automatic step8_t bcd_step(input logic [7:0] v, input logic [7:0] last,
                                      input logic [7:0] first);
    step8_t r;
    if (v == last) begin
      r.wrap = 1'b1;
      r.val  = first;
    end else if (v[3:0] >= 4'd9) begin
      r.wrap = 1'b0;
      r.val  = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r.wrap = 1'b0;
      r.val  = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // BCD year divisible by four: ones + 2*(tens mod 2) divisible by four.
  function automatic logic leap_year(input logic [7:0] yr);
    logic [4:0] s;
    s = {1'b0, yr[3:0]} + {3'b000, yr[4], 1'b0};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [3:0] mon, input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      4'd2:                    d = leap_year(yr) ? 8'h29 : 8'h28;
      4'd4, 4'd6, 4'd9, 4'd11: d = 8'h30;
      default:                 d = 8'h31;
    endcase
    return d;
  endfunction

  // Calendar advance by one second.
  function automatic cal_t calendar_next(input cal_t c, input logic serial);
    cal_t   n;
    step8_t s;
    n = c;
    s = bcd_step(c[0], 8'h59, 8'h00);
    n[0] = s.val;
    if (s.wrap) begin
      s = bcd_step(c[1], 8'h59, 8'h00);
      n[1] = s.val;
      if (s.wrap) begin
        s = bcd_step(c[2], 8'h23, 8'h00);
        n[2] = s.val;
        if (s.wrap) begin
          n[4][3:0] = (c[4][3:0] >= 4'd6) ? 4'd0 : c[4][3:0] + 4'd1;
          s = bcd_step(c[3], last_day(c[4][7:4], c[5]), 8'h01);
          n[3] = s.val;
          if (s.wrap) begin
            if (c[4][7:4] >= 4'd12) begin
              n[4][7:4] = 4'd1;
              if (serial) begin
                s = bcd_step(c[5], 8'h99, 8'h00);
                n[5] = s.val;
              end
            end else begin
              n[4][7:4] = c[4][7:4] + 4'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

  // Test step, one ripple chain across the active bytes.
  function automatic test_res_t test_ripple(input cal_t c, input logic serial);
    test_res_t r;
    logic      carry;
    r.cal  = c;
    r.flag = serial ? (c[5] == 8'h00) : (c[4] == 8'h00);
    carry  = 1'b1;
    for (int i = 0; i < CAL_BYTES; i++) begin
      if ((i < PAR_BYTES || serial) && carry) begin
        r.cal[i] = c[i] + 8'd1;
        carry    = (r.cal[i] == 8'h00);
      end
    end
    return r;
  endfunction

  // Test step, every active byte counts on its own.
  function automatic test_res_t test_parallel(input cal_t c, input logic serial);
    test_res_t r;
    r.cal  = c;
    r.flag = 1'b0;
    for (int i = 0; i < CAL_BYTES; i++) begin
      if (i < PAR_BYTES || serial) begin
        r.cal[i] = c[i] + 8'd1;
        if (r.cal[i] == 8'h00) r.flag = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_sec_divider.sv
module cal_sec_divider #(
  parameter int DIV_BITS  = 15,
  parameter int KEEP_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic count_en,
  input  logic clear_upper,
  output logic sec_tick
);

  localparam int HI_W = DIV_BITS - KEEP_BITS;

  logic [KEEP_BITS-1:0] lo_q;
  logic [HI_W-1:0]      hi_q;
  logic                 lo_wrap;

  assign lo_wrap  = ref_tick & (&lo_q);
  assign sec_tick = lo_wrap & count_en & (&hi_q);

  // low stages free-run on every reference pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_q <= '0;
    else if (ref_tick) lo_q <= lo_q + 1'b1;
  end

  // upper stages advance only while counting; a time set clears them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hi_q <= '0;
    else if (clear_upper)          hi_q <= '0;
    else if (lo_wrap && count_en)  hi_q <= hi_q + 1'b1;
  end

endmodule

// File: rtl/cal_test_prescaler.sv
module cal_test_prescaler #(
  parameter int TEST_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic test_en,
  output logic test_step
);

  logic [TEST_BITS-1:0] tp_q;

  assign test_step = test_en & ref_tick & (&tp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tp_q <= '0;
    else if (!test_en) tp_q <= '0;
    else if (ref_tick) tp_q <= tp_q + 1'b1;
  end

endmodule

// File: rtl/cal_step_unit.sv
module cal_step_unit
  import cal_pkg::*;
(
  input  cal_t             cur,
  input  logic             serial_mode,
  input  logic             oe,
  input  logic             test_en,
  input  logic             sec_tick,
  input  logic             test_step,
  input  logic             load_stb,
  input  logic [CAL_W-1:0] load_data,
  input  logic             flag_q,
  output cal_t             nxt,
  output logic             flag_nxt
);

  cal_t      loaded;
  cal_t      counted;
  test_res_t rip;
  test_res_t par;

  // per-byte load mux; the year byte is written only in serial mode
  for (genvar g = 0; g < CAL_BYTES; g++) begin : g_load
    if (g < PAR_BYTES) begin : g_always
      assign loaded[g] = load_data[8*g +: 8];
    end else begin : g_serial
      assign loaded[g] = serial_mode ? load_data[8*g +: 8] : cur[g];
    end
  end

  assign counted = calendar_next(cur, serial_mode);
  assign rip     = test_ripple(cur, serial_mode);
  assign par     = test_parallel(cur, serial_mode);

  // priority: load, then test step, then second tick
  always_comb begin
    nxt      = cur;
    flag_nxt = test_en ? flag_q : 1'b0;
    if (load_stb) begin
      nxt = loaded;
    end else if (test_step) begin
      if (oe) begin
        nxt      = rip.cal;
        flag_nxt = rip.flag;
      end else begin
        nxt      = par.cal;
        flag_nxt = par.flag;
      end
    end else if (sec_tick) begin
      nxt = counted;
    end
  end

endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int DIV_BITS  = 15,
  parameter int KEEP_BITS = 9,
  parameter int TEST_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             load_stb,
  input  logic [CAL_W-1:0] load_data,
  input  logic             run_en,
  input  logic             test_en,
  input  logic             oe,
  input  logic             serial_mode,
  output logic [CAL_W-1:0] cal_bytes,
  output logic             test_flag
);

  cal_t cal_q;
  cal_t cal_d;
  logic flag_q;
  logic flag_d;
  logic halt_q;
  logic run_q;
  logic test_q;
  logic restart;
  logic count_en;
  logic sec_tick;
  logic test_step;

  assign restart  = (run_en & ~run_q) | (test_q & ~test_en);
  assign count_en = run_en & ~halt_q & ~test_en;

  cal_sec_divider #(
    .DIV_BITS  (DIV_BITS),
    .KEEP_BITS (KEEP_BITS)
  ) div_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .count_en    (count_en),
    .clear_upper (load_stb),
    .sec_tick    (sec_tick)
  );

  cal_test_prescaler #(
    .TEST_BITS (TEST_BITS)
  ) tpre_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .test_en   (test_en),
    .test_step (test_step)
  );

  cal_step_unit step_i (
    .cur         (cal_q),
    .serial_mode (serial_mode),
    .oe          (oe),
    .test_en     (test_en),
    .sec_tick    (sec_tick),
    .test_step   (test_step),
    .load_stb    (load_stb),
    .load_data   (load_data),
    .flag_q      (flag_q),
    .nxt         (cal_d),
    .flag_nxt    (flag_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= CAL_RESET;
      flag_q <= 1'b0;
      halt_q <= 1'b0;
      run_q  <= 1'b0;
      test_q <= 1'b0;
    end else begin
      cal_q  <= cal_d;
      flag_q <= flag_d;
      run_q  <= run_en;
      test_q <= test_en;
      if (load_stb)     halt_q <= 1'b1;
      else if (restart) halt_q <= 1'b0;
    end
  end

  assign cal_bytes = cal_q;
  assign test_flag = flag_q;

endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        test_en,
  input logic        serial_mode,
  input logic        load_stb,
  input logic [47:0] load_data,
  input logic [47:0] cal_q,
  input logic        sec_tick,
  input logic        test_step,
  input logic        test_flag
);

  p_tick_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !load_stb) |=> (cal_q[7:0] != $past(cal_q[7:0])));

  p_year_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_mode |=> $stable(cal_q[47:40]));

  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !test_en && !load_stb) |=> $stable(cal_q));

  p_load_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (cal_q[39:0] == $past(load_data[39:0])));

  p_load_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && serial_mode) |=> (cal_q == $past(load_data)));

  p_test_step_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (test_step && !load_stb) |=> (cal_q[7:0] != $past(cal_q[7:0])));

  p_flag_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !test_flag);

endmodule

bind cal_counter cal_counter_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .test_en     (test_en),
  .serial_mode (serial_mode),
  .load_stb    (load_stb),
  .load_data   (load_data),
  .cal_q       (cal_q),
  .sec_tick    (sec_tick),
  .test_step   (test_step),
  .test_flag   (test_flag)
);

// File: tb/cal_counter_tb_top.sv
module cal_counter_tb_top;

  localparam int DIVB   = 4;
  localparam int KEEPB  = 2;
  localparam int TESTB  = 2;
  localparam int PERIOD = 1 << DIVB;
  localparam int LO_P   = 1 << KEEPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        load_stb = 1'b0;
  logic [47:0] load_data = '0;
  logic        run_en = 1'b0;
  logic        test_en = 1'b0;
  logic        oe = 1'b0;
  logic        serial_mode = 1'b1;
  logic [47:0] cal_bytes;
  logic        test_flag;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;

  always #5 clk = ~clk;

  cal_counter #(
    .DIV_BITS  (DIVB),
    .KEEP_BITS (KEEPB),
    .TEST_BITS (TESTB)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .load_stb    (load_stb),
    .load_data   (load_data),
    .run_en      (run_en),
    .test_en     (test_en),
    .oe          (oe),
    .serial_mode (serial_mode),
    .cal_bytes   (cal_bytes),
    .test_flag   (test_flag)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_cal(input string tag, input logic [47:0] exp);
    checks++;
    if (cal_bytes !== exp) begin
      errors++;
      $display("FAIL %s: cal_bytes actual %h expected %h", tag, cal_bytes, exp);
    end
  endtask

  task automatic chk_flag(input string tag, input logic exp);
    checks++;
    if (test_flag !== exp) begin
      errors++;
      $display("FAIL %s: test_flag actual %b expected %b", tag, test_flag, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      cyc();
      ref_cnt++;
    end
    ref_tick = 1'b0;
  endtask

  task automatic load(input logic [47:0] d);
    load_stb  = 1'b1;
    load_data = d;
    cyc();
    load_stb  = 1'b0;
  endtask

  task automatic restart();
    run_en = 1'b0;
    cyc();
    run_en = 1'b1;
    cyc();
  endtask

  function automatic int to_tick();
    return PERIOD - (ref_cnt % LO_P);
  endfunction

  task automatic tick_from_load(input string tag, input logic [47:0] d, input logic [47:0] exp);
    load(d);
    restart();
    pulse(to_tick());
    chk_cal(tag, exp);
  endtask

  task automatic t_reset();
    chk_cal("R1 reset calendar", 48'h00_10_01_00_00_00);
    chk_flag("R1 reset flag", 1'b0);
  endtask

  task automatic t_second_tick();
    load(48'h24_32_15_10_20_05);
    restart();
    pulse(to_tick() - 1);
    chk_cal("R8 no tick one pulse early", 48'h24_32_15_10_20_05);
    pulse(1);
    chk_cal("R8 first tick after time set", 48'h24_32_15_10_20_06);
    pulse(PERIOD - 1);
    chk_cal("R2 no tick before full period", 48'h24_32_15_10_20_06);
    pulse(1);
    chk_cal("R2 tick after full period", 48'h24_32_15_10_20_07);
  endtask

  task automatic t_bcd_rollover();
    load(48'h24_32_15_23_59_58);
    restart();
    pulse(to_tick());
    chk_cal("R3 seconds to 59", 48'h24_32_15_23_59_59);
    pulse(PERIOD);
    chk_cal("R3 sec/min/hour rollover", 48'h24_33_16_00_00_00);
  endtask

  task automatic t_month_end();
    tick_from_load("R4 leap Feb 28 stays Feb", 48'h24_20_28_23_59_59, 48'h24_21_29_00_00_00);
    tick_from_load("R4 leap Feb 29 to Mar", 48'h24_26_29_23_59_59, 48'h24_30_01_00_00_00);
    tick_from_load("R4 plain Feb 28 to Mar", 48'h23_21_28_23_59_59, 48'h23_32_01_00_00_00);
    tick_from_load("R4 Apr 30 to May", 48'h24_44_30_23_59_59, 48'h24_55_01_00_00_00);
    tick_from_load("R4 Dec 31 year 99 wrap", 48'h99_C3_31_23_59_59, 48'h00_14_01_00_00_00);
  endtask

  task automatic t_parallel_year();
    load(48'h99_C3_31_23_59_59);
    serial_mode = 1'b0;
    load(48'h77_C3_31_23_59_59);
    chk_cal("R5 load leaves year", 48'h99_C3_31_23_59_59);
    restart();
    pulse(to_tick());
    chk_cal("R5 no year carry", 48'h99_14_01_00_00_00);
  endtask

  task automatic t_run_gate();
    run_en = 1'b0;
    cyc();
    pulse(3 * PERIOD);
    chk_cal("R6 run_en low holds", 48'h99_14_01_00_00_00);
    run_en = 1'b1;
    cyc();
    serial_mode = 1'b1;
  endtask

  task automatic t_load_hold();
    load(48'h24_32_15_10_20_05);
    chk_cal("R7 load value", 48'h24_32_15_10_20_05);
    pulse(3 * PERIOD);
    chk_cal("R7 halted after load", 48'h24_32_15_10_20_05);
  endtask

  task automatic t_load_priority();
    restart();
    pulse(to_tick() - 1);
    ref_tick  = 1'b1;
    load_stb  = 1'b1;
    load_data = 48'h24_32_15_01_02_03;
    cyc();
    ref_cnt++;
    ref_tick = 1'b0;
    load_stb = 1'b0;
    chk_cal("R14 load beats tick", 48'h24_32_15_01_02_03);
    pulse(PERIOD);
    chk_cal("R14 halted after colliding load", 48'h24_32_15_01_02_03);
  endtask

  task automatic t_test_ripple();
    serial_mode = 1'b1;
    oe          = 1'b1;
    test_en     = 1'b1;
    cyc();
    load(48'h00_00_00_00_09_FF);
    pulse((1 << TESTB) - 1);
    chk_cal("R9 no step before prescale", 48'h00_00_00_00_09_FF);
    pulse(1);
    chk_cal("R10 ripple binary step", 48'h00_00_00_00_0A_00);
    chk_flag("R10 flag top byte zero", 1'b1);
    load(48'h00_FF_FF_FF_FF_FF);
    pulse(1 << TESTB);
    chk_cal("R12 serial chain reaches year", 48'h01_00_00_00_00_00);
    serial_mode = 1'b0;
    load(48'h55_FF_FF_FF_FF_FF);
    pulse(1 << TESTB);
    chk_cal("R12 parallel chain stops at byte 4", 48'h01_00_00_00_00_00);
    chk_flag("R12 flag from byte 4", 1'b0);
  endtask

  task automatic t_test_parallel();
    serial_mode = 1'b1;
    oe          = 1'b0;
    load(48'h05_30_00_FF_12_FF);
    restart();
    pulse(1 << TESTB);
    chk_cal("R11 independent step", 48'h06_31_01_00_13_00);
    chk_flag("R11 flag on wrap", 1'b1);
    pulse(1 << TESTB);
    chk_cal("R11 second step", 48'h07_32_02_01_14_01);
    chk_flag("R11 flag no wrap", 1'b0);
    pulse(4 << TESTB);
    chk_cal("R9 no normal tick in test mode", 48'h0B_36_06_05_18_05);
  endtask

  task automatic t_test_exit();
    test_en = 1'b0;
    cyc();
    chk_flag("R13 flag cleared", 1'b0);
    chk_cal("R13 exit holds value", 48'h0B_36_06_05_18_05);
    pulse(PERIOD);
    chk_cal("R13 normal counting resumes", 48'h0B_36_06_05_18_06);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    run_en = 1'b1;
    cyc();
    t_reset();
    t_second_tick();
    t_bcd_rollover();
    t_month_end();
    t_parallel_year();
    t_run_gate();
    t_load_hold();
    t_load_priority();
    t_test_ripple();
    t_test_parallel();
    t_test_exit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule